// File: doc/BRIEF.md
# Capture Pixel Format Packer

This block takes pixels with 5 bits per colour channel from a legacy video source. It converts each one into one of four memory formats and presents the result as a little-endian word with a byte-enable mask. The word goes to a write stream. There are two formats with 8 bits per channel (with or without an alpha byte) and two 16-bit formats.

Channels are widened to 8 bits by a left shift. Green also gets a small fixed bias. An optional ordered-dither offset can be added. The offset is picked per pixel column from a 16-bit pattern word. The pattern value 0xCCCC gives no dithering at all.

Both sides use a valid/ready handshake. One output word is produced per accepted pixel, one cycle after acceptance. The format select, alpha byte and dither pattern are sampled together with each pixel. They may change from one pixel to the next.

Top module: `capture_pixel_packer`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `out_valid` is 0 and `in_ready` is 1.
- R2: The format code is `ctrl_word[9:8]`: 0 = ABGR8, 1 = BGR8, 2 = RGB565, 3 = A1BGR5.
  - The byte enables are 4'b1111, 4'b0111, 4'b0011 and 4'b0011 respectively.
  - Data bytes whose enable is 0 read as zero.
- R3: In the 8-bit formats, with no dither, red and blue each become their 5-bit value shifted left by 3.
- R4: In the 8-bit formats, with no dither, green becomes its 5-bit value shifted left by 3, plus 2.
- R5: Byte layout of the 8-bit formats:
  - ABGR8: byte0 = alpha, byte1 = blue, byte2 = green, byte3 = red.
  - BGR8: byte0 = blue, byte1 = green, byte2 = red.
- R6: RGB565 layout: bits 15:11 = red8[7:3], bits 10:5 = green8[7:2], bits 4:0 = blue8[7:3]. Here red8, green8 and blue8 are the 8-bit channel values after expansion and dither.
- R7: A1BGR5 layout: bit 15 = alpha bit 7, bits 14:10 = raw red, bits 9:5 = raw green, bits 4:0 = raw blue. The dither pattern has no effect in this format.
- R8: Dither in formats 0 to 2:
  - The pixel's column is the count of pixels accepted since the last pixel with `in_sol` high, modulo 4. A pixel with `in_sol` high is column 0.
  - The column selects the nibble `dither_pat[4c+3:4c]`.
  - The offset is (nibble − 12), read as a 4-bit signed value (range −8 to +7).
  - The offset is added to each 8-bit channel, and the result is saturated to 0..255.
  - A pattern of 0xCCCC changes nothing.
- R9: Handshake:
  - `in_ready` is high when no word is held, or when the held word is being taken.
  - A held word and its enables stay unchanged while `out_ready` is low.
  - Each accepted pixel yields exactly one word, in order, with `out_valid` high in the cycle after acceptance.
- R10: Format, alpha and dither pattern are taken from the cycle in which the pixel is accepted. Changes while a pixel waits, or between pixels, affect only the pixels accepted after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 16 | Control word; bits 9:8 select the format |
| alpha_val | input | 8 | Constant alpha byte |
| dither_pat | input | 16 | Four 4-bit dither entries, one per column |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_sol | input | 1 | Pixel is the first of a line |
| in_r | input | 5 | Red channel |
| in_g | input | 5 | Green channel |
| in_b | input | 5 | Blue channel |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 32 | Packed pixel word, little-endian |
| out_be | output | 4 | Byte enables for out_data |

## Verification
Pixel values are swept in every format.
- Extreme channel values (0 and 31) separate the green bias from the red and blue shift. They also separate byte order from bit order.
- Mixed values expose swapped channels.
- Dither patterns include 0xCCCC, a uniform +1, a uniform −8 and a per-column mix.
- Those patterns are driven with lines that restart part-way through a column cycle. This tells column tracking apart from a plain pixel counter, and shows saturation at both ends.
- A1BGR5 is also run with a non-trivial pattern, to show that the pattern is ignored there.
- Random backpressure, combined with a format change on every pixel, checks stall stability and sampling at acceptance.

// File: rtl/cpk_pkg.sv
// Shared types for the capture pixel packer.
// Assumes 8-bit wide channels for the expanded pixel.
package cpk_pkg;
    localparam int WIDE_W = 8;

    typedef enum logic [1:0] {
        FMT_ABGR8  = 2'd0,
        FMT_BGR8   = 2'd1,
        FMT_RGB565 = 2'd2,
        FMT_A1BGR5 = 2'd3
    } cpk_fmt_e;

    typedef struct packed {
        logic [WIDE_W-1:0] r;
        logic [WIDE_W-1:0] g;
        logic [WIDE_W-1:0] b;
    } wide_px_t;
endpackage

// File: rtl/cpk_dither_sel.sv
// Picks the dither entry for a pixel column and turns it into a signed offset.
// Assumes PAT_W == COLS * ENT_W. An entry equal to NEUTRAL yields offset zero.
module cpk_dither_sel #(
    parameter int PAT_W   = 16,
    parameter int COLS    = 4,
    parameter int ENT_W   = 4,
    parameter int NEUTRAL = 12,
    localparam int COL_W  = $clog2(COLS)
) (
    input  logic [PAT_W-1:0]        pattern,
    input  logic [COL_W-1:0]        col,
    output logic signed [ENT_W-1:0] offset
);
    logic [ENT_W-1:0] entry;

    // Select the entry of the current column and remove the neutral bias.
    always_comb begin
        entry  = pattern[col*ENT_W +: ENT_W];
        offset = $signed(entry - ENT_W'(NEUTRAL));
    end
endmodule

// File: rtl/cpk_expand.sv
// Widens 5-bit channels to 8 bits (shift, green bias), adds a signed
// dither offset and saturates to the 8-bit range.
// Assumes OUT_W > IN_W and OFF_W < OUT_W.
module cpk_expand
    import cpk_pkg::*;
#(
    parameter int IN_W   = 5,
    parameter int OUT_W  = 8,
    parameter int OFF_W  = 4,
    parameter int G_BIAS = 2,
    localparam int SHIFT = OUT_W - IN_W,
    localparam int SUM_W = OUT_W + 2
) (
    input  logic [IN_W-1:0]         r,
    input  logic [IN_W-1:0]         g,
    input  logic [IN_W-1:0]         b,
    input  logic signed [OFF_W-1:0] offset,
    output wide_px_t                px
);
    logic [IN_W-1:0]  ch_in  [3];
    logic [OUT_W-1:0] ch_out [3];

    // Gather the channels in a fixed order: red, green, blue.
    always_comb begin
        ch_in[0] = r;
        ch_in[1] = g;
        ch_in[2] = b;
    end

    for (genvar i = 0; i < 3; i++) begin : g_ch
        localparam int BIAS = (i == 1) ? G_BIAS : 0;
        logic [OUT_W-1:0]        base;
        logic signed [SUM_W-1:0] sum;

        // Shift, bias, add offset and clamp one channel.
        always_comb begin
            base = {ch_in[i], {SHIFT{1'b0}}} + OUT_W'(BIAS);
            sum  = $signed({2'b00, base})
                 + $signed({{(SUM_W-OFF_W){offset[OFF_W-1]}}, offset});
            if (sum < 0)
                ch_out[i] = '0;
            else if (sum > $signed(SUM_W'((1 << OUT_W) - 1)))
                ch_out[i] = '1;
            else
                ch_out[i] = sum[OUT_W-1:0];
        end
    end

    // Assemble the wide pixel.
    always_comb begin
        px.r = ch_out[0];
        px.g = ch_out[1];
        px.b = ch_out[2];
    end
endmodule

// File: rtl/cpk_pack.sv
// Packs a wide pixel (or the raw channels) into a little-endian word and
// derives the byte-enable mask from the format. Unused bytes are zero.
module cpk_pack
    import cpk_pkg::*;
#(
    parameter int IN_W   = 5,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  cpk_fmt_e          fmt,
    input  wide_px_t          px,
    input  logic [IN_W-1:0]   raw_r,
    input  logic [IN_W-1:0]   raw_g,
    input  logic [IN_W-1:0]   raw_b,
    input  logic [7:0]        alpha,
    output logic [DATA_W-1:0] data,
    output logic [BE_W-1:0]   be
);
    // Format-specific byte placement and enable mask.
    always_comb begin
        data = '0;
        be   = '0;
        unique case (fmt)
            FMT_ABGR8: begin
                data[31:0] = {px.r, px.g, px.b, alpha};
                be         = BE_W'(4'b1111);
            end
            FMT_BGR8: begin
                data[23:0] = {px.r, px.g, px.b};
                be         = BE_W'(4'b0111);
            end
            FMT_RGB565: begin
                data[15:0] = {px.r[7:3], px.g[7:2], px.b[7:3]};
                be         = BE_W'(4'b0011);
            end
            FMT_A1BGR5: begin
                data[15:0] = {alpha[7], raw_r, raw_g, raw_b};
                be         = BE_W'(4'b0011);
            end
            default: begin
                data = '0;
                be   = '0;
            end
        endcase
    end
endmodule

// File: rtl/capture_pixel_packer.sv
// Top of the capture pixel packer: column tracking, format conversion and a
// single output register with valid/ready flow control.
// Assumes COLS is a power of two and ctrl_word carries the format at FMT_LSB.
module capture_pixel_packer
    import cpk_pkg::*;
#(
    parameter int CH_W    = 5,
    parameter int CTRL_W  = 16,
    parameter int FMT_LSB = 8,
    parameter int COLS    = 4,
    parameter int ENT_W   = 4,
    parameter int DATA_W  = 32,
    localparam int PAT_W  = COLS * ENT_W,
    localparam int COL_W  = $clog2(COLS),
    localparam int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [7:0]        alpha_val,
    input  logic [PAT_W-1:0]  dither_pat,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sol,
    input  logic [CH_W-1:0]   in_r,
    input  logic [CH_W-1:0]   in_g,
    input  logic [CH_W-1:0]   in_b,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [BE_W-1:0]   out_be
);
    cpk_fmt_e               fmt;
    logic [COL_W-1:0]       col_q;
    logic [COL_W-1:0]       col_cur;
    logic signed [ENT_W-1:0] dith_off;
    wide_px_t               wide_px;
    logic [DATA_W-1:0]      pack_data;
    logic [BE_W-1:0]        pack_be;
    logic                   accept;

    // Decode the format field and the handshake.
    always_comb begin
        fmt      = cpk_fmt_e'(ctrl_word[FMT_LSB +: 2]);
        in_ready = !out_valid || out_ready;
        accept   = in_valid && in_ready;
        col_cur  = in_sol ? '0 : col_q;
    end

    cpk_dither_sel #(
        .PAT_W (PAT_W),
        .COLS  (COLS),
        .ENT_W (ENT_W)
    ) u_dsel (
        .pattern (dither_pat),
        .col     (col_cur),
        .offset  (dith_off)
    );

    // The A1BGR5 format carries raw channels, so no offset is applied there.
    logic signed [ENT_W-1:0] eff_off;
    always_comb eff_off = (fmt == FMT_A1BGR5) ? '0 : dith_off;

    cpk_expand #(
        .IN_W  (CH_W),
        .OUT_W (WIDE_W),
        .OFF_W (ENT_W)
    ) u_exp (
        .r      (in_r),
        .g      (in_g),
        .b      (in_b),
        .offset (eff_off),
        .px     (wide_px)
    );

    cpk_pack #(
        .IN_W   (CH_W),
        .DATA_W (DATA_W)
    ) u_pack (
        .fmt   (fmt),
        .px    (wide_px),
        .raw_r (in_r),
        .raw_g (in_g),
        .raw_b (in_b),
        .alpha (alpha_val),
        .data  (pack_data),
        .be    (pack_be)
    );

    // Advance the column on every accepted pixel; a line start restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            col_q <= '0;
        else if (accept)
            col_q <= col_cur + COL_W'(1);
    end

    // Output register: load on accept, release when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_be    <= '0;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_data  <= pack_data;
            out_be    <= pack_be;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R9: a stalled word stays put.
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_be));

    // R9: an accepted pixel shows up on the next cycle.
    p_accept_to_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R2: enables are always one of the legal masks.
    p_be_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_be == 4'b1111 || out_be == 4'b0111 || out_be == 4'b0011));

    // R3: undithered ABGR8 red is the shifted input.
    p_red_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept && fmt == FMT_ABGR8 && dither_pat == 16'hCCCC
        |=> out_data[31:24] == {$past(in_r), 3'b000});
endmodule

// File: tb/capture_pixel_packer_test.sv
module capture_pixel_packer_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] ctrl_word;
    logic [7:0]  alpha_val;
    logic [15:0] dither_pat;
    logic        in_valid, in_ready, in_sol;
    logic [4:0]  in_r, in_g, in_b;
    logic        out_valid, out_ready;
    logic [31:0] out_data;
    logic [3:0]  out_be;

    always #(PERIOD/2) clk = ~clk;

    capture_pixel_packer uut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .alpha_val(alpha_val),
        .dither_pat(dither_pat), .in_valid(in_valid), .in_ready(in_ready),
        .in_sol(in_sol), .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_be(out_be)
    );

    typedef struct {
        logic [31:0] d;
        logic [3:0]  be;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   colcnt  = 0;
    bit   bp      = 0;
    bit   got     = 0;

    function automatic int clamp8(input int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction

    // Behavioural model of one output word from the requirements.
    function automatic exp_t model(input int r, g, b, fmt, a, pat, col, string tag);
        exp_t e;
        int off, r8, g8, b8;
        off = ((pat >> (4 * col)) & 15) - 12;
        if (off < -8) off += 16;
        if (fmt == 3) off = 0;
        r8 = clamp8(r * 8 + off);
        g8 = clamp8(g * 8 + 2 + off);
        b8 = clamp8(b * 8 + off);
        e.tag = tag;
        case (fmt)
            0: begin e.d = 32'((r8 << 24) | (g8 << 16) | (b8 << 8) | a); e.be = 4'hF; end
            1: begin e.d = 32'((r8 << 16) | (g8 << 8) | b8);             e.be = 4'h7; end
            2: begin e.d = 32'(((r8 >> 3) << 11) | ((g8 >> 2) << 5) | (b8 >> 3)); e.be = 4'h3; end
            default: begin e.d = 32'(((a >> 7) << 15) | (r << 10) | (g << 5) | b); e.be = 4'h3; end
        endcase
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock: set backpressure, compare against the model, track handshakes.
    task automatic step(input string tag);
        bit fire_in, fire_out;
        int col;
        out_ready = bp ? (($urandom % 3) != 0) : 1'b1;
        #1;
        fire_in  = in_valid && in_ready;
        fire_out = out_valid && out_ready;
        check(out_valid == (q.size() != 0), tag, "out_valid", 32'(out_valid), 32'(q.size() != 0));
        if (out_valid && q.size() != 0) begin
            check(out_data == q[0].d, q[0].tag, "out_data", out_data, q[0].d);
            check(out_be == q[0].be, q[0].tag, "out_be", 32'(out_be), 32'(q[0].be));
            if (fire_out) void'(q.pop_front());
        end
        if (fire_in) begin
            col = in_sol ? 0 : colcnt;
            q.push_back(model(in_r, in_g, in_b, ctrl_word[9:8], alpha_val, dither_pat, col % 4, tag));
            colcnt = (col + 1) % 4;
            got = 1;
        end
        @(negedge clk);
    endtask

    task automatic send(input int r, g, b, fmt, a, pat, bit sol, string tag);
        in_valid = 1'b1;
        in_r = 5'(r); in_g = 5'(g); in_b = 5'(b);
        ctrl_word = 16'(fmt << 8) | 16'h00A5;
        alpha_val = 8'(a); dither_pat = 16'(pat); in_sol = sol;
        got = 0;
        do step(tag); while (!got);
        in_valid = 1'b0;
        in_sol   = 1'b0;
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 20 && q.size() != 0; i++) step(tag);
        step(tag);
        check(q.size() == 0, tag, "drain", 32'(q.size()), 32'd0);
    endtask

    initial begin
        #(PERIOD * 150000);
        n_fail++;
        $display("FAIL R9 watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sol = 1'b0; out_ready = 1'b1;
        ctrl_word = '0; alpha_val = 8'hFF; dither_pat = 16'hCCCC;
        in_r = '0; in_g = '0; in_b = '0;
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready in reset", 32'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 1);
        @(negedge clk);

        // R3 / R4 / R5: extremes and mixes in both 8-bit formats, no dither.
        send(31, 0, 0, 0, 8'hFF, 16'hCCCC, 1, "R3");
        send(0, 0, 31, 0, 8'h80, 16'hCCCC, 0, "R3");
        send(0, 31, 0, 0, 8'h3C, 16'hCCCC, 0, "R4");
        send(0, 0, 0, 1, 8'hFF, 16'hCCCC, 0, "R4");
        send(17, 9, 4, 1, 8'hFF, 16'hCCCC, 1, "R5");
        send(3, 22, 30, 0, 8'h01, 16'hCCCC, 0, "R5");
        // R2: unused bytes zero across formats.
        send(31, 31, 31, 1, 8'hFF, 16'hCCCC, 0, "R2");
        send(31, 31, 31, 2, 8'hFF, 16'hCCCC, 0, "R2");
        // R6: RGB565 patterns.
        send(31, 31, 31, 2, 8'h00, 16'hCCCC, 1, "R6");
        send(1, 2, 4, 2, 8'h00, 16'hCCCC, 0, "R6");
        send(16, 8, 0, 2, 8'h00, 16'hCCCC, 0, "R6");
        // R7: A1BGR5 raw pass, alpha bit 7, dither ignored.
        send(21, 10, 5, 3, 8'h80, 16'h4444, 1, "R7");
        send(31, 0, 31, 3, 8'h7F, 16'h3333, 0, "R7");
        send(0, 31, 0, 3, 8'hFF, 16'hDDDD, 0, "R7");
        drain("R2");

        // R8: dither patterns, saturation and column restart mid-cycle.
        for (int i = 0; i < 6; i++) send(31, 31, 31, 0, 8'hFF, 16'h3333, i == 0, "R8");
        for (int i = 0; i < 6; i++) send(0, 0, 0, 1, 8'hFF, 16'h4444, i == 0, "R8");
        for (int i = 0; i < 7; i++) send(10, 20, 5, 0, 8'hFF, 16'hC3DB, i == 0 || i == 3, "R8");
        for (int i = 0; i < 5; i++) send(9, 13, 27, 2, 8'hFF, 16'hDDDD, i == 2, "R8");
        drain("R8");

        // R9 / R10: random backpressure, format and settings change per pixel.
        bp = 1;
        for (int i = 0; i < 200; i++)
            send($urandom % 32, $urandom % 32, $urandom % 32, i % 4, $urandom % 256,
                 (i % 3 == 0) ? 16'hCCCC : $urandom % 65536, (i % 7) == 0,
                 (i % 2) ? "R9" : "R10");
        bp = 0;
        drain("R9");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule